// File: doc/BRIEF.md
# External Interrupt Trigger Mode Register

This block holds the trigger configuration for a set of external interrupt groups and turns raw interrupt lines into request set strobes for the interrupt controller. Each group has a 2-bit mode code, and four codes are packed into one byte. A small byte-wide register port reads and writes these bytes. Each bank address selects one byte, which covers four consecutive groups.

The detection side samples each raw line once per clock. In either edge mode, any change of a line since the previous clock raises that group's set strobe for one cycle, whether the line rose or fell. In either level mode, the strobe follows the line: it is asserted while the line is 1, whatever polarity the code names. The strobes only set requests. Clearing requests and choosing among them belong to the consumer.

The decoded mode codes are also driven out, so the request-latching logic can see how each group is configured.

Top module: `ext_trig_cfg`

## Requirements
- R1: Group 4*b+k (k = 0..3) is stored in bits 2k+1:2k of bank byte b. With `cfg_addr` = b, `cfg_rdata` combinationally returns that byte, and `trig_mode[2g+1:2g]` presents the code of group g.
- R2: A clock edge with `cfg_we` high replaces all four codes of the bank selected by `cfg_addr` with `cfg_wdata`. The other bank keeps its value.
- R3: After reset every code is 0. The encoding is 0 = negative edge, 1 = positive edge, 2 = low level, 3 = high level.
- R4: In an edge mode (code 0 or 1), `req_set[g]` is high in a cycle exactly when `irq_in[g]` differs from its value at the previous clock edge. Rising and falling changes both count, and the strobe lasts one cycle.
- R5: In a level mode (code 2 or 3), `req_set[g]` equals `irq_in[g]` in every cycle, regardless of which level code is programmed.
- R6: A mode write alone never produces an edge strobe. The line history is tracked in every mode, so a group switched into an edge mode while its line is steady shows no strobe.
- R7: Without a write, the stored codes do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | ADDR_W | Bank byte select |
| cfg_wdata | input | 8 | Write data, four packed codes |
| cfg_we | input | 1 | Write enable |
| cfg_rdata | output | 8 | Read data of the selected bank |
| irq_in | input | NG | Raw external interrupt lines |
| trig_mode | output | 2*NG | Mode code of each group |
| req_set | output | NG | Request set strobes |

## Verification
The hardest situation to reach is a mode change on a group whose line is already steady. That situation shows whether the edge history keeps running while a group is in a level mode. The bench holds a line high for many cycles in negative-edge mode and switches the group to low-level, where the strobe must follow the line. It then switches the group back to an edge mode and checks, in the first cycle after the write, that no strobe appears.

// File: rtl/ext_trig_cfg.sv
module ext_trig_cfg #(
  parameter int NUM_BANKS = 2,
  localparam int NG = NUM_BANKS * 4,
  localparam int ADDR_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              cfg_we,
  output logic [7:0]        cfg_rdata,
  input  logic [NG-1:0]     irq_in,
  output logic [2*NG-1:0]   trig_mode,
  output logic [NG-1:0]     req_set
);

  logic [2*NG-1:0] mode_q;
  logic [NG-1:0]   prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_q <= '0;
    else if (cfg_we && int'(cfg_addr) < NUM_BANKS)
      mode_q[int'(cfg_addr)*8 +: 8] <= cfg_wdata;

  always_ff @(posedge clk) prev_q <= irq_in;

  always_comb begin
    cfg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (int'(cfg_addr) == b) cfg_rdata = mode_q[b*8 +: 8];
  end

  assign trig_mode = mode_q;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign req_set[g] = mode_q[2*g+1] ? irq_in[g] : (irq_in[g] ^ prev_q[g]);

    AST_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_mode[2*g+1] && $stable(irq_in[g])) |-> !req_set[g]); // R4
    AST_LEVEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_mode[2*g+1] && !irq_in[g]) |-> !req_set[g]); // R5
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && int'(cfg_addr) == b) |=> trig_mode[b*8 +: 8] == $past(cfg_wdata)); // R2
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> trig_mode == '0); // R3
  AST_HOLD_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(trig_mode)); // R7

endmodule

// File: tb/sim_ext_trig_cfg.sv
`timescale 1ns/1ps
module sim_ext_trig_cfg;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [0:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       cfg_we = 0;
  logic [7:0] cfg_rdata;
  logic [7:0] irq_in = '0;
  logic [15:0] trig_mode;
  logic [7:0] req_set;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ext_trig_cfg #(.NUM_BANKS(2)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [0:0] a, logic [7:0] d);
    @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_we = 1;
    @(posedge clk); #1 cfg_we = 0;
  endtask

  task automatic step_check(int g, logic v, logic exp, string req);
    @(negedge clk); irq_in[g] = v; #1;
    chk(req, req_set[g], exp);
  endtask

  task automatic t_reset;
    cfg_addr = 0; #1; chk("R3 bank0 reset", cfg_rdata, 8'h00);
    cfg_addr = 1; #1; chk("R3 bank1 reset", cfg_rdata, 8'h00);
    chk("R3 modes reset", trig_mode, 16'h0000);
  endtask

  task automatic t_regs;
    wr(0, 8'hE4);
    cfg_addr = 0; #1; chk("R1 bank0 read", cfg_rdata, 8'hE4);
    chk("R1 group2 code", trig_mode[5:4], 2'd2);
    chk("R1 group3 code", trig_mode[7:6], 2'd3);
    cfg_addr = 1; #1; chk("R2 bank1 untouched", cfg_rdata, 8'h00);
    wr(1, 8'h1B);
    cfg_addr = 1; #1; chk("R2 bank1 write", cfg_rdata, 8'h1B);
    chk("R1 group4 code", trig_mode[9:8], 2'd3);
    cfg_addr = 0; #1; chk("R2 bank0 kept", cfg_rdata, 8'hE4);
    repeat (3) @(posedge clk);
    #1 chk("R7 codes hold", trig_mode, 16'h1BE4);
    wr(1, 8'h00);
  endtask

  task automatic t_edge;
    step_check(0, 1, 1, "R4 neg-edge mode rise");
    step_check(0, 1, 0, "R4 strobe one cycle");
    step_check(0, 0, 1, "R4 neg-edge mode fall");
    step_check(1, 1, 1, "R4 pos-edge mode rise");
    step_check(1, 1, 0, "R4 pos-edge steady");
    step_check(1, 0, 1, "R4 pos-edge mode fall");
  endtask

  task automatic t_level;
    step_check(2, 1, 1, "R5 low-level code asserts on 1");
    step_check(2, 1, 1, "R5 level held");
    step_check(2, 0, 0, "R5 level released");
    step_check(3, 1, 1, "R5 high-level code asserts on 1");
    step_check(3, 1, 1, "R5 high level held");
    step_check(3, 0, 0, "R5 high level released");
  endtask

  task automatic t_switch;
    step_check(4, 1, 1, "R4 group4 rise");
    repeat (4) @(posedge clk);
    #1 chk("R6 steady no strobe", req_set[4], 1'b0);
    wr(1, 8'h02);
    chk("R6 level mode follows line", req_set[4], 1'b1);
    repeat (2) @(posedge clk);
    wr(1, 8'h01);
    chk("R6 back to edge no strobe", req_set[4], 1'b0);
    @(negedge clk); #1 chk("R6 still quiet", req_set[4], 1'b0);
    step_check(4, 0, 1, "R4 fall after switch");
  endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        #1 t_reset();
        @(negedge clk) rst_n = 1;
        t_regs();
        wr(0, 8'hE4);
        t_edge();
        t_level();
        t_switch();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule